// File: doc/BRIEF.md
# GF(2^3) Scalar-by-Vector Multiplier

The block multiplies one element of the eight-element binary extension field by every lane of a vector of field elements. Each element is a 3-bit word whose bits are the coefficients of a polynomial over GF(2). Bit 0 is the constant term. Products are reduced modulo x^3 + x + 1. Field addition is a carry-free XOR.

The scalar is expanded once into its three basis multiples: scalar·α^0, scalar·α^1 and scalar·α^2. Each multiple comes from the one before by a left shift, followed by a conditional XOR with 3'b011. Every lane then forms its product as the XOR of those shared multiples, each gated by the matching bit of that lane's element. The lanes share the expansion, so there is no per-lane multiplier and no carry logic. The result is an AND/XOR network.

A parameter selects between two output modes. In the registered mode, one output stage captures the products and the valid flag. In the combinational mode, results appear in the same cycle as the inputs. Lane k of the vector ports occupies bits [3k+2:3k].

Top module: `gf8_vec_scale`

## Requirements
- R1: Each product lane equals the polynomial product of the scalar and that lane's element over GF(2), reduced modulo x^3 + x + 1. This holds for all 8 scalars and all 512 vector values.
- R2: A zero scalar gives zero on every product lane.
- R3: A lane whose element is 3'b000 gives 3'b000. A lane whose element is 3'b001 gives the scalar unchanged.
- R4: For a nonzero scalar, the seven nonzero elements map to seven distinct nonzero products.
- R5: With OUT_REG=1, valid_o equals valid_i delayed by one clock. A valid input appears on prod_o one clock later.
- R6: With OUT_REG=1, prod_o holds its value while valid_i is low, whatever the scalar and vector inputs do.
- R7: With OUT_REG=0, valid_o equals valid_i and prod_o is the product of the present inputs in the same cycle.
- R8: With OUT_REG=1, while rst_ni is low, valid_o is 0 and prod_o is all zero.
- R9: The product is linear in the element: scalar·(a XOR b) equals (scalar·a) XOR (scalar·b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input qualifier |
| scalar_i | input | ELEM_W | Scalar field element |
| vec_i | input | NUM_ELEM*ELEM_W | Vector of field elements, lane k at bits [k*ELEM_W +: ELEM_W] |
| valid_o | output | 1 | Output qualifier |
| prod_o | output | NUM_ELEM*ELEM_W | Product vector, laid out the same way as vec_i |

## Verification
The bench builds two copies side by side with NUM_ELEM=3, ELEM_W=3 and RED_MASK=3'b011. One uses OUT_REG=1 and the other OUT_REG=0, and both are driven from the same stimulus.

The registered copy covers the one-cycle valid latency, the hold behaviour while valid is low, and the reset values. The combinational copy gives same-cycle products. On those products the bench checks the permutation property of each nonzero scalar's row and the linearity in the element, using lanes whose elements are XOR-related.

All 4096 pairs of scalar and vector run through both copies. The results are compared against a bitwise multiply-and-reduce model.

// File: rtl/gf8_pkg.sv
package gf8_pkg;
  localparam int unsigned ElemW   = 3;
  localparam int unsigned NumElem = 3;
  // low bits of x^3 + x + 1, folded in when alpha^3 is shifted out
  localparam logic [ElemW-1:0] RedMask = 3'b011;
endpackage

// File: rtl/gf8_basis_gen.sv
// scalar * alpha^k for k = 0 .. W-1, shared by all lanes
module gf8_basis_gen #(
  parameter int unsigned W          = gf8_pkg::ElemW,
  parameter logic [W-1:0] RED_MASK  = gf8_pkg::RedMask
) (
  input  logic [W-1:0]         scalar_i,
  output logic [W-1:0][W-1:0]  basis_o
);

  assign basis_o[0] = scalar_i;

  for (genvar k = 1; k < W; k++) begin : g_pow
    logic [W-1:0] shifted;
    assign shifted    = {basis_o[k-1][W-2:0], 1'b0};
    assign basis_o[k] = basis_o[k-1][W-1] ? (shifted ^ RED_MASK) : shifted;

    // field multiplication by alpha is a bijection on nonzero values
    always_comb begin
      if (scalar_i != '0) begin
        AST_BASIS_NONZERO: assert (basis_o[k] != '0); // R4
      end
    end
  end

endmodule

// File: rtl/gf8_subset_xor.sv
// one lane: XOR of the shared basis terms picked by the element bits
module gf8_subset_xor #(
  parameter int unsigned W = gf8_pkg::ElemW
) (
  input  logic [W-1:0][W-1:0] basis_i,
  input  logic [W-1:0]        elem_i,
  output logic [W-1:0]        prod_o
);

  always_comb begin
    prod_o = '0;
    for (int k = 0; k < W; k++) begin
      prod_o = prod_o ^ (basis_i[k] & {W{elem_i[k]}});
    end
  end

  always_comb begin
    if (elem_i == '0) begin
      AST_ZERO_ELEM: assert (prod_o == '0); // R3
    end
  end

endmodule

// File: rtl/gf8_out_reg.sv
module gf8_out_reg #(
  parameter int unsigned DW = gf8_pkg::NumElem * gf8_pkg::ElemW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R5
  AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R5
  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> data_o == $past(data_i)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o)); // R6

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!valid_o && data_o == '0); // R8
    end
  end

endmodule

// File: rtl/gf8_vec_scale.sv
module gf8_vec_scale #(
  parameter int unsigned NUM_ELEM       = gf8_pkg::NumElem,
  parameter int unsigned ELEM_W         = gf8_pkg::ElemW,
  parameter logic [ELEM_W-1:0] RED_MASK = gf8_pkg::RedMask,
  parameter bit OUT_REG                 = 1'b1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [ELEM_W-1:0]            scalar_i,
  input  logic [NUM_ELEM*ELEM_W-1:0]   vec_i,
  output logic                         valid_o,
  output logic [NUM_ELEM*ELEM_W-1:0]   prod_o
);

  localparam int unsigned DW = NUM_ELEM * ELEM_W;

  logic [ELEM_W-1:0][ELEM_W-1:0] basis;
  logic [DW-1:0]                 prod_d;

  gf8_basis_gen #(
    .W        (ELEM_W),
    .RED_MASK (RED_MASK)
  ) i_basis (
    .scalar_i (scalar_i),
    .basis_o  (basis)
  );

  for (genvar l = 0; l < NUM_ELEM; l++) begin : g_lane
    gf8_subset_xor #(
      .W (ELEM_W)
    ) i_lane (
      .basis_i (basis),
      .elem_i  (vec_i[l*ELEM_W +: ELEM_W]),
      .prod_o  (prod_d[l*ELEM_W +: ELEM_W])
    );
  end

  if (OUT_REG) begin : g_reg
    gf8_out_reg #(
      .DW (DW)
    ) i_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .data_i  (prod_d),
      .valid_o (valid_o),
      .data_o  (prod_o)
    );

    AST_ZERO_SCALAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && scalar_i == '0 |=> prod_o == '0); // R2
    for (genvar l = 0; l < NUM_ELEM; l++) begin : g_chk
      AST_UNIT_ELEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && vec_i[l*ELEM_W +: ELEM_W] == ELEM_W'(1)
        |=> prod_o[l*ELEM_W +: ELEM_W] == $past(scalar_i)); // R3
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign prod_o  = prod_d;

    AST_ZERO_SCALAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && scalar_i == '0 |-> prod_o == '0); // R2
    for (genvar l = 0; l < NUM_ELEM; l++) begin : g_chk
      AST_UNIT_ELEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_i[l*ELEM_W +: ELEM_W] == ELEM_W'(1)
        |-> prod_o[l*ELEM_W +: ELEM_W] == scalar_i); // R3
    end
  end

endmodule

// File: tb/test_gf8_vec_scale.sv
module test_gf8_vec_scale;
  localparam int N  = 3;
  localparam int W  = 3;
  localparam int DW = N * W;
  localparam logic [2*W-2:0] POLY = 5'b01011;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          valid_i = 1'b0;
  logic [W-1:0]  scalar_i = '0;
  logic [DW-1:0] vec_i = '0;
  logic          valid_o, valid_c;
  logic [DW-1:0] prod_o, prod_c;

  gf8_vec_scale #(.NUM_ELEM(N), .ELEM_W(W), .RED_MASK(3'b011), .OUT_REG(1'b1)) i_gf8_vec_scale (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .scalar_i(scalar_i),
    .vec_i(vec_i), .valid_o(valid_o), .prod_o(prod_o));

  gf8_vec_scale #(.NUM_ELEM(N), .ELEM_W(W), .RED_MASK(3'b011), .OUT_REG(1'b0)) i_gf8_vec_scale_comb (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .scalar_i(scalar_i),
    .vec_i(vec_i), .valid_o(valid_c), .prod_o(prod_c));

  typedef struct { logic [DW-1:0] val; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] last_exp = '0;
  bit prev_idle = 1'b0;

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-2:0] t = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) t = t ^ ((2*W-1)'(a) << i);
    for (int i = 2*W-2; i >= W; i--)
      if (t[i]) t = t ^ (POLY << (i - W));
    return t[W-1:0];
  endfunction

  function automatic logic [DW-1:0] ref_vec(input logic [W-1:0] s, input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int l = 0; l < N; l++) r[l*W +: W] = ref_mul(s, v[l*W +: W]);
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [W-1:0] s, input logic [DW-1:0] v, input string req);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1; scalar_i = s; vec_i = v; prev_idle = 1'b0;
    e.val = ref_vec(s, v); e.req = req;
    exp_q.push_back(e);
    last_exp = e.val;
    #1;
    check("R7", DW'(valid_c), DW'(1'b1));
    check({req, "/R7"}, prod_c, e.val);
  endtask

  task automatic idle(input logic [W-1:0] s, input logic [DW-1:0] v);
    @(negedge clk);
    if (prev_idle) begin
      check("R6", prod_o, last_exp);
      check("R5", DW'(valid_o), '0);
    end
    valid_i = 1'b0; scalar_i = s; vec_i = v; prev_idle = 1'b1;
    #1;
    check("R7", DW'(valid_c), '0);
  endtask

  // monitor: registered copy against scoreboard
  initial begin
    logic v_s;
    exp_t e;
    forever begin
      @(posedge clk);
      v_s = valid_i;
      @(negedge clk);
      if (rst_ni) begin
        check("R5", DW'(valid_o), DW'(v_s));
        if (valid_o) begin
          if (exp_q.size() == 0) check("R5", prod_o, 'x);
          else begin
            e = exp_q.pop_front();
            check(e.req, prod_o, e.val);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] seen;
    logic [W-1:0] a, b;
    repeat (3) @(negedge clk);
    check("R8", DW'(valid_o), '0);   // R8 valid low in reset
    check("R8", prod_o, '0);         // R8 products cleared
    rst_ni = 1'b1;

    apply(3'd0, 9'h1FF, "R2");
    apply(3'd5, {3'd1, 3'd0, 3'd2}, "R3");
    apply(3'd7, {3'd0, 3'd1, 3'd1}, "R3");
    idle(3'd6, 9'h155);
    idle(3'd3, 9'h0AA);
    idle(3'd1, 9'h1FF);
    apply(3'd4, 9'h0F3, "R5");

    for (int s = 0; s < 8; s++) begin
      seen = '0;
      for (int v = 0; v < 512; v++) begin
        apply(W'(s), DW'(v), "R1");
        a = DW'(v) >> 0; b = W'(v >> W);
        if (v[2:0] != 0) seen[prod_c[2:0]] = 1'b1;
        if (v[8:6] == (v[2:0] ^ v[5:3]))
          check("R9", DW'(prod_c[8:6]), DW'(prod_c[2:0] ^ prod_c[5:3]));
      end
      if (s != 0) check("R4", DW'(seen), DW'(8'hFE));
    end
    idle(3'd2, 9'h000);
    idle(3'd5, 9'h1C7);
    idle(3'd0, 9'h000);
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R5", DW'(exp_q.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule